// File: doc/BRIEF.md
# Hard-Fault Self-Test Sequencer

This block sweeps a set of router sub-units, one after another, looking for permanent stuck-at faults. A start pulse comes with a selection mask; every selected unit is tested in ascending index order, and unselected units are skipped. A parameter fixes each unit's kind. Logic-style units get pseudo-random stimulus from a 16-bit LFSR for a fixed run. Their responses are compacted into a multiple-input signature register (MISR), and the final signature is compared with a per-unit golden value. Datapath-style units get a fixed walking pattern instead: a lone one, then a lone zero, stepped across every bit of the word. Each response bit that differs from the word sent is counted.

At the end of each unit's run, the block writes one fault bit for that unit into the reconfiguration table, addressed by the unit index. The write of one unit's result and the seeding of the next unit's test share a single cycle, so the sweep has no dead cycles beyond one evaluation cycle per unit. One cycle after the last write, a single-cycle done pulse ends the sweep.

Top module: `bist_sequencer`

## Requirements
- R1: While reset is asserted, done, tblWe and stimValid are all low.
- R2: For a logic-style unit (DP_MASK bit 0), stimValid is high for exactly PAT_LEN (256) consecutive cycles. Every 16-bit lane of stimOut carries the same LFSR state. That state starts at 0xACE1 and advances each cycle as s' = {s[14:0], s[15]^s[13]^s[12]^s[10]}, which is the polynomial x^16+x^14+x^13+x^11+1.
- R3: For a logic-style unit, the signature starts at zero and updates each stimulus cycle as m' = {m[14:0], m[15]^m[13]^m[12]^m[10]} XOR (XOR of all 16-bit lanes of respIn). The fault bit written is 1 exactly when the final signature differs from that unit's 16-bit slice of EXP_SIG (unit i at bits 16i+15..16i).
- R4: For a datapath-style unit (DP_MASK bit 1), stimValid is high for 2*DATA_W cycles. In step k with k < DATA_W, stimOut has only bit k set. In step k with k >= DATA_W, stimOut is all ones except bit k-DATA_W. The fault bit is 1 exactly when at least one respIn bit differs from stimOut across the run.
- R5: Each selected unit gets exactly one table write, in ascending index order, with tblAddr set to the unit index. The write comes in the cycle right after that unit's last stimulus cycle. Unselected units get no stimulus and no write.
- R6: done is high for one cycle, in the cycle after the last table write. If the mask is empty, done comes in the cycle after start and no write occurs.
- R7: A start pulse during a sweep is ignored: no extra unit is tested and no extra done occurs.
- R8: When another selected unit follows, its first stimulus cycle is the cycle right after the previous unit's table write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Starts a sweep when idle |
| unitSel | input | NUM_UNITS | Mask of units to test, sampled with start |
| stimValid | output | 1 | Stimulus is being applied this cycle |
| stimUnit | output | log2(NUM_UNITS) | Index of the unit receiving stimulus |
| stimOut | output | DATA_W | Stimulus word |
| respIn | input | DATA_W | Response of the selected unit, same cycle |
| tblWe | output | 1 | Table write strobe |
| tblAddr | output | log2(NUM_UNITS) | Table entry (unit index) |
| tblFault | output | 1 | Fault bit written |
| done | output | 1 | One-cycle end-of-sweep pulse |

## Verification
The functions that coincide are the table write of one unit and the re-seeding of the counters and LFSR for the next selected unit. Both happen in the evaluation cycle. This case is provoked by selecting adjacent units of different kinds (a logic unit followed by a datapath unit) with stuck-at faults in each. The check then confirms two things: the first unit's fault bit is correct even though its signature is discarded in that same cycle, and the second unit's stimulus matches the expected pattern from its first step onward, with no stale count or LFSR state. A start pulse arriving in the middle of a sweep is judged by counting table writes and done pulses.

// File: rtl/bist_pkg.sv
package bist_pkg;

  localparam int SIG_W = 16;

  typedef struct packed {
    logic clr;     // reseed LFSR, clear signature, flip and step counts
    logic step;    // one stimulus cycle
    logic dpMode;  // current unit uses the walking-bit routine
  } bistCmd_t;

  function automatic logic [SIG_W-1:0] lfsrNext(logic [SIG_W-1:0] s);
    return {s[SIG_W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

endpackage

// File: rtl/bist_ctrl.sv
module bist_ctrl
  import bist_pkg::*;
#(
  parameter int NUM_UNITS = 8,
  parameter logic [NUM_UNITS-1:0] DP_MASK = '0,
  parameter logic [NUM_UNITS*SIG_W-1:0] EXP_SIG = '0
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          start,
  input  logic [NUM_UNITS-1:0]          unitSel,
  input  logic                          lastStep,
  output bistCmd_t                      cmd,
  output logic [SIG_W-1:0]              expSig,
  output logic [$clog2(NUM_UNITS)-1:0]  unitIdx,
  output logic                          stimValid,
  output logic                          tblWe,
  output logic                          done
);

  localparam int IDX_W = $clog2(NUM_UNITS);

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_EVAL, ST_FIN} ctrlState_t;

  ctrlState_t state;
  logic [NUM_UNITS-1:0] selMask;
  logic [IDX_W-1:0]     firstIdx, nextIdx;
  logic                 firstHit, nextHit;

  // lowest selected unit in the incoming mask
  always_comb begin
    firstHit = 1'b0;
    firstIdx = '0;
    for (int i = NUM_UNITS - 1; i >= 0; i--) begin
      if (unitSel[i]) begin
        firstHit = 1'b1;
        firstIdx = IDX_W'(i);
      end
    end
  end

  // lowest selected unit above the current one
  always_comb begin
    nextHit = 1'b0;
    nextIdx = '0;
    for (int i = NUM_UNITS - 1; i >= 0; i--) begin
      if (selMask[i] && ((IDX_W+1)'(i) > {1'b0, unitIdx})) begin
        nextHit = 1'b1;
        nextIdx = IDX_W'(i);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      selMask <= '0;
      unitIdx <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            selMask <= unitSel;
            if (firstHit) begin
              unitIdx <= firstIdx;
              state   <= ST_RUN;
            end else begin
              state <= ST_FIN;
            end
          end
        end
        ST_RUN: begin
          if (lastStep) state <= ST_EVAL;
        end
        ST_EVAL: begin
          if (nextHit) begin
            unitIdx <= nextIdx;
            state   <= ST_RUN;
          end else begin
            state <= ST_FIN;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    cmd.clr    = ((state == ST_IDLE) && start && firstHit) ||
                 ((state == ST_EVAL) && nextHit);
    cmd.step   = (state == ST_RUN);
    cmd.dpMode = DP_MASK[unitIdx];
  end

  assign expSig    = EXP_SIG[unitIdx*SIG_W +: SIG_W];
  assign stimValid = (state == ST_RUN);
  assign tblWe     = (state == ST_EVAL);
  assign done      = (state == ST_FIN);

endmodule

// File: rtl/bist_dpath.sv
module bist_dpath
  import bist_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PAT_LEN = 256,
  parameter logic [SIG_W-1:0] SEED = 16'hACE1
) (
  input  logic              clk,
  input  logic              rstN,
  input  bistCmd_t          cmd,
  input  logic [SIG_W-1:0]  expSig,
  input  logic [DATA_W-1:0] respIn,
  output logic [DATA_W-1:0] stimOut,
  output logic              lastStep,
  output logic              faultOut
);

  localparam int WALK_LEN = 2 * DATA_W;
  localparam int MAX_LEN  = (PAT_LEN > WALK_LEN) ? PAT_LEN : WALK_LEN;
  localparam int CNT_W    = $clog2(MAX_LEN);
  localparam int FLIP_W   = $clog2(WALK_LEN * DATA_W + 1);
  localparam int LANES    = DATA_W / SIG_W;

  logic [SIG_W-1:0]  lfsr, misr, foldResp;
  logic [CNT_W-1:0]  stepCnt, walkPos;
  logic [FLIP_W-1:0] flipCnt, diffCnt;
  logic              walkOne;
  logic [DATA_W-1:0] walkPat, patStim;

  // walking pattern: lone one for the first DATA_W steps, lone zero after
  assign walkOne = stepCnt < CNT_W'(DATA_W);
  assign walkPos = walkOne ? stepCnt : stepCnt - CNT_W'(DATA_W);

  always_comb begin
    for (int b = 0; b < DATA_W; b++) begin
      walkPat[b] = (walkPos == CNT_W'(b)) ? walkOne : !walkOne;
    end
  end

  // every lane carries the LFSR state
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign patStim[l*SIG_W +: SIG_W] = lfsr;
  end

  always_comb begin
    foldResp = '0;
    for (int l = 0; l < LANES; l++) begin
      foldResp = foldResp ^ respIn[l*SIG_W +: SIG_W];
    end
  end

  assign diffCnt  = FLIP_W'($countones(respIn ^ walkPat));
  assign stimOut  = cmd.dpMode ? walkPat : patStim;
  assign lastStep = cmd.dpMode ? (stepCnt == CNT_W'(WALK_LEN - 1))
                               : (stepCnt == CNT_W'(PAT_LEN - 1));
  assign faultOut = cmd.dpMode ? (flipCnt != '0) : (misr != expSig);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lfsr    <= SEED;
      misr    <= '0;
      stepCnt <= '0;
      flipCnt <= '0;
    end else if (cmd.clr) begin
      lfsr    <= SEED;
      misr    <= '0;
      stepCnt <= '0;
      flipCnt <= '0;
    end else if (cmd.step) begin
      lfsr    <= lfsrNext(lfsr);
      misr    <= lfsrNext(misr) ^ foldResp;
      stepCnt <= stepCnt + 1'b1;
      if (cmd.dpMode) flipCnt <= flipCnt + diffCnt;
    end
  end

endmodule

// File: rtl/bist_sequencer.sv
module bist_sequencer
  import bist_pkg::*;
#(
  parameter int NUM_UNITS = 8,
  parameter int DATA_W = 32,
  parameter int PAT_LEN = 256,
  parameter logic [SIG_W-1:0] SEED = 16'hACE1,
  parameter logic [NUM_UNITS-1:0] DP_MASK = 8'hF0,
  parameter logic [NUM_UNITS*SIG_W-1:0] EXP_SIG = '0
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          start,
  input  logic [NUM_UNITS-1:0]          unitSel,
  output logic                          stimValid,
  output logic [$clog2(NUM_UNITS)-1:0]  stimUnit,
  output logic [DATA_W-1:0]             stimOut,
  input  logic [DATA_W-1:0]             respIn,
  output logic                          tblWe,
  output logic [$clog2(NUM_UNITS)-1:0]  tblAddr,
  output logic                          tblFault,
  output logic                          done
);

  bistCmd_t         cmd;
  logic [SIG_W-1:0] expSig;
  logic             lastStep;
  logic [$clog2(NUM_UNITS)-1:0] unitIdx;

  bist_ctrl #(
    .NUM_UNITS(NUM_UNITS),
    .DP_MASK  (DP_MASK),
    .EXP_SIG  (EXP_SIG)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .unitSel  (unitSel),
    .lastStep (lastStep),
    .cmd      (cmd),
    .expSig   (expSig),
    .unitIdx  (unitIdx),
    .stimValid(stimValid),
    .tblWe    (tblWe),
    .done     (done)
  );

  bist_dpath #(
    .DATA_W (DATA_W),
    .PAT_LEN(PAT_LEN),
    .SEED   (SEED)
  ) u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .cmd     (cmd),
    .expSig  (expSig),
    .respIn  (respIn),
    .stimOut (stimOut),
    .lastStep(lastStep),
    .faultOut(tblFault)
  );

  assign stimUnit = unitIdx;
  assign tblAddr  = unitIdx;

endmodule

// File: rtl/bist_checker.sv
module bist_checker
  import bist_pkg::*;
#(
  parameter int NUM_UNITS = 8,
  parameter int DATA_W = 32,
  parameter logic [NUM_UNITS-1:0] DP_MASK = 8'hF0
) (
  input logic                          clk,
  input logic                          rstN,
  input logic                          stimValid,
  input logic [$clog2(NUM_UNITS)-1:0]  stimUnit,
  input logic [DATA_W-1:0]             stimOut,
  input logic                          tblWe,
  input logic                          done
);

  localparam int LANES = DATA_W / SIG_W;

  logic [DATA_W-1:0] laneRep;
  for (genvar l = 0; l < LANES; l++) begin : g_rep
    assign laneRep[l*SIG_W +: SIG_W] = stimOut[SIG_W-1:0];
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rstN |-> (!done && !tblWe && !stimValid));

  assert_lane_copy_R2: assert property (@(posedge clk) disable iff (!rstN)
    (stimValid && !DP_MASK[stimUnit]) |-> (stimOut == laneRep));

  assert_lfsr_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    (stimValid && $past(stimValid) && !DP_MASK[stimUnit] && (stimUnit == $past(stimUnit)))
      |-> (stimOut[SIG_W-1:0] == lfsrNext($past(stimOut[SIG_W-1:0]))));

  assert_walk_shape_R4: assert property (@(posedge clk) disable iff (!rstN)
    (stimValid && DP_MASK[stimUnit])
      |-> (($countones(stimOut) == 1) || ($countones(stimOut) == DATA_W - 1)));

  assert_write_single_R5: assert property (@(posedge clk) disable iff (!rstN)
    tblWe |=> !tblWe);

  assert_write_after_stim_R5: assert property (@(posedge clk) disable iff (!rstN)
    tblWe |-> $past(stimValid));

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_done_quiet_R6: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!stimValid && !tblWe));

  assert_follow_on_R8: assert property (@(posedge clk) disable iff (!rstN)
    tblWe |=> (stimValid != done));

endmodule

bind bist_sequencer bist_checker #(
  .NUM_UNITS(NUM_UNITS),
  .DATA_W   (DATA_W),
  .DP_MASK  (DP_MASK)
) u_chk (.*);

// File: tb/bist_sequencer_bench.sv
`timescale 1ns/1ps
module bist_sequencer_bench;
  import bist_pkg::*;

  localparam int NU = 8;
  localparam int DW = 32;
  localparam int PL = 256;
  localparam logic [15:0] SD = 16'hACE1;
  localparam logic [NU-1:0] DPM = 8'hF0;

  function automatic logic [31:0] goodPat(logic [31:0] s);
    return {s[15:0] ^ 16'h3C3C, s[26:16], s[31:27]};
  endfunction

  function automatic logic [31:0] withStuck(logic [31:0] r, bit en, int b, bit v);
    logic [31:0] o;
    o = r;
    if (en) o[b] = v;
    return o;
  endfunction

  function automatic logic [15:0] sigOf(bit en, int b, bit v);
    logic [15:0] l, m;
    logic [31:0] r;
    l = SD;
    m = '0;
    for (int k = 0; k < PL; k++) begin
      r = withStuck(goodPat({l, l}), en, b, v);
      m = lfsrNext(m) ^ (r[31:16] ^ r[15:0]);
      l = lfsrNext(l);
    end
    return m;
  endfunction

  localparam logic [15:0] GOLD = sigOf(1'b0, 0, 1'b0);
  localparam logic [NU*16-1:0] EXPS = {NU{GOLD}};

  logic clk = 0, rstN = 0, start = 0;
  logic [NU-1:0] unitSel = '0;
  logic stimValid, tblWe, tblFault, done;
  logic [2:0] stimUnit, tblAddr;
  logic [DW-1:0] stimOut, respIn;

  bit stuckEn [NU];
  int stuckBit [NU];
  bit stuckVal [NU];

  always #2 clk = ~clk;

  bist_sequencer #(
    .NUM_UNITS(NU), .DATA_W(DW), .PAT_LEN(PL), .SEED(SD),
    .DP_MASK(DPM), .EXP_SIG(EXPS)
  ) u_bist_sequencer (
    .clk(clk), .rstN(rstN), .start(start), .unitSel(unitSel),
    .stimValid(stimValid), .stimUnit(stimUnit), .stimOut(stimOut),
    .respIn(respIn), .tblWe(tblWe), .tblAddr(tblAddr),
    .tblFault(tblFault), .done(done)
  );

  // unit stubs: datapath units pass through, logic units scramble
  always_comb begin
    logic [31:0] base;
    base = DPM[stimUnit] ? stimOut : goodPat(stimOut);
    respIn = withStuck(base, stuckEn[stimUnit], stuckBit[stimUnit], stuckVal[stimUnit]);
  end

  int total = 0, bad = 0;

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  typedef struct { int addr; bit fault; } expItem_t;
  expItem_t q[$];
  bit expDone = 0, expEmpty = 0;
  int weCount = 0;

  // monitor: samples just after each rising edge
  initial begin
    bit prevValid = 0, prevWe = 0, prevDone = 0, afterWe = 0;
    int k = 0, runErr = 0;
    logic [15:0] ml = SD;
    logic [31:0] ex;
    expItem_t e;
    forever begin
      @(posedge clk); #1;
      if (rstN) begin
        if (stimValid) begin
          if (!prevValid) begin k = 0; runErr = 0; ml = SD; end
          if (DPM[stimUnit])
            ex = (k < DW) ? (32'h1 << k) : ~(32'h1 << (k - DW));
          else
            ex = {ml, ml};
          if (stimOut !== ex) runErr++;
          ml = lfsrNext(ml);
          k++;
        end
        if (afterWe) begin
          chk(stimValid == (q.size() > 0), "R8 next unit starts right after write",
              stimValid, q.size() > 0);
          afterWe = 0;
        end
        if (tblWe) begin
          weCount++;
          chk(prevValid, "R5 write follows last stimulus", prevValid, 1);
          if (q.size() == 0) begin
            chk(0, "R5 unexpected table write", tblAddr, 0);
          end else begin
            e = q.pop_front();
            chk(tblAddr == e.addr, "R5 write address order", tblAddr, e.addr);
            if (DPM[e.addr]) begin
              chk(tblFault == e.fault, "R4 datapath fault bit", tblFault, e.fault);
              chk(k == 2*DW && runErr == 0, "R4 walking pattern and length", k, 2*DW);
            end else begin
              chk(tblFault == e.fault, "R3 signature fault bit", tblFault, e.fault);
              chk(k == PL && runErr == 0, "R2 LFSR stimulus and length", k, PL);
            end
          end
          afterWe = 1;
        end
        if (done) begin
          chk(expDone, "R6 done only at end of sweep", done, expDone);
          chk(q.size() == 0, "R6 all writes before done", q.size(), 0);
          chk(prevWe || expEmpty, "R6 done one cycle after last write", prevWe, 1);
          chk(!prevDone, "R6 done lasts one cycle", prevDone, 0);
          expDone = 0;
        end
        prevValid = stimValid;
        prevWe = tblWe;
        prevDone = done;
      end
    end
  end

  task automatic runSweep(logic [NU-1:0] mask);
    expItem_t e;
    for (int i = 0; i < NU; i++) begin
      if (mask[i]) begin
        e.addr = i;
        e.fault = DPM[i] ? stuckEn[i] : (sigOf(stuckEn[i], stuckBit[i], stuckVal[i]) != GOLD);
        q.push_back(e);
      end
    end
    expDone = 1;
    expEmpty = (mask == '0);
    @(negedge clk);
    start = 1;
    unitSel = mask;
    @(negedge clk);
    start = 0;
    while (expDone) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic clearFaults();
    for (int i = 0; i < NU; i++) begin
      stuckEn[i] = 0; stuckBit[i] = 0; stuckVal[i] = 0;
    end
  endtask

  task automatic setFault(int u, int b, bit v);
    stuckEn[u] = 1; stuckBit[u] = b; stuckVal[u] = v;
  endtask

  initial begin
    #(100000 * 4);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int wBefore;
    clearFaults();
    repeat (3) @(negedge clk);
    chk(!done, "R1 done low in reset", done, 0);
    chk(!tblWe, "R1 tblWe low in reset", tblWe, 0);
    chk(!stimValid, "R1 stimValid low in reset", stimValid, 0);
    rstN = 1;
    repeat (2) @(negedge clk);

    // all units, fault-free
    runSweep(8'hFF);

    // faults in a logic unit and a datapath unit
    setFault(1, 7, 0);
    setFault(5, 20, 1);
    runSweep(8'hFF);

    // adjacent logic->datapath units, unselected faulty unit 0
    clearFaults();
    setFault(0, 15, 1);
    setFault(3, 31, 1);
    setFault(4, 0, 0);
    runSweep(8'h18);

    // empty mask: done the cycle after start
    clearFaults();
    expDone = 1;
    expEmpty = 1;
    wBefore = weCount;
    @(negedge clk);
    start = 1;
    unitSel = '0;
    @(posedge clk); #1;
    chk(done, "R6 empty mask done next cycle", done, 1);
    @(negedge clk);
    start = 0;
    repeat (3) @(negedge clk);
    chk(weCount == wBefore, "R6 empty mask no write", weCount - wBefore, 0);

    // start during a sweep is ignored
    setFault(7, 9, 1);
    wBefore = weCount;
    q.push_back('{addr: 7, fault: 1'b1});
    expDone = 1;
    expEmpty = 0;
    @(negedge clk);
    start = 1;
    unitSel = 8'h80;
    @(negedge clk);
    start = 0;
    repeat (10) @(negedge clk);
    start = 1;
    unitSel = 8'hFF;
    @(negedge clk);
    start = 0;
    while (expDone) @(negedge clk);
    repeat (300) @(negedge clk);
    chk(weCount - wBefore == 1, "R7 start ignored while busy", weCount - wBefore, 1);

    // more stuck-at positions
    clearFaults();
    setFault(2, 16, 0);
    setFault(6, 3, 1);
    runSweep(8'h44);

    clearFaults();
    runSweep(8'h81);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule